// File: doc/BRIEF.md
# Status Register Write Guard

This block sits between the command decoder of a serial flash controller and its configuration register. It decides whether a status-write command may change the configuration word. It keeps the write-enable latch and models the busy interval of non-volatile operations with a counter. The inputs are single-cycle command strobes from the decoder, the active-low write-protect pin, the quad-command-mode flag, and the 16-bit image that the non-volatile cells give at power-up. The outputs are the live configuration word, the latch and busy bits, and a pulse that marks each status write that was accepted.

A two-bit protect field selects the write permission. The field can leave writes open, tie them to the pin, lock them until the next power cycle, or lock them for good. The three security lock bits can only be set. The quad-enable bit cannot be cleared while quad command mode is active. Reserved positions can never hold a one. The reset input stands for a power cycle: the latch and busy bit clear, and the configuration word reloads from the image.

Top module: `sr_write_guard`

## Requirements
- R1: Configuration word layout: bit 0 protect-low, bit 1 protect-high, bit 2 quad-enable, bits 5:3 lock bits, bits 11:6 protection configuration, bits 15:12 reserved. With the protect field at 00, a status write with the latch set is accepted whatever the pin level.
- R2: With the protect field at 01, a status write is refused while the write-protect pin is low and quad-enable is 0. It is accepted when the pin is high, or when quad-enable is 1 (the pin is then a data lane and its level is ignored).
- R3: With the protect field at 10, every status write is refused. A power cycle with 10 in the image loads 00 into the protect field.
- R4: With the protect field at 11, every status write is refused. The value 11 survives a power cycle.
- R5: A write-enable strobe sets the latch and a write-disable strobe clears it. A power cycle clears the latch and the busy bit.
- R6: An accepted program, erase, security program, security erase or status write clears the latch and sets busy. Busy stays high for T_SR cycles after a status write and for T_ARRAY cycles after the other operations.
- R7: While busy is high, every command strobe is ignored: the latch and the configuration word do not change.
- R8: With the latch clear, program, erase, security and status-write strobes are rejected and busy stays low. A status write refused by the protect field leaves the latch set and starts no busy interval.
- R9: An accepted status write ORs the written lock bits into the stored ones, so a lock bit that is 1 never returns to 0.
- R10: In quad command mode, a status write cannot change quad-enable from 1 to 0, but it can set it. Outside that mode, quad-enable takes the written value.
- R11: Reserved bits 15:12 read as 0 after a power cycle and after any write, whatever value was loaded or written.
- R12: An accepted status write raises wr_accept for exactly one cycle, in the cycle after the strobe. In that same cycle the protect field and the configuration bits take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as a power cycle |
| nv_word | input | 16 | Non-volatile image loaded while reset is low |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_prog | input | 1 | Array program strobe |
| cmd_erase | input | 1 | Array erase strobe |
| cmd_sec_prog | input | 1 | Security register program strobe |
| cmd_sec_erase | input | 1 | Security register erase strobe |
| wr_data | input | 16 | Word carried by a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| qpi_mode | input | 1 | Quad command mode is active |
| wr_accept | output | 1 | One-cycle pulse for an accepted status write |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Non-volatile operation in progress |
| sr_word | output | 16 | Current configuration word |

## Verification
The properties assume that the decoder raises at most one command strobe in any cycle, and they check that assumption directly. They also assume that a power cycle holds reset low for at least one clock edge, so that the configuration word is loaded before it is judged. The bench drives one strobe per cycle, on the falling edge, and holds reset low for two cycles at every power cycle. It sweeps all combinations of protect field, quad-enable, pin level and quad mode. Directed sequences then cover power cycles, busy intervals, lock bits and reserved bits.

// File: rtl/sr_guard_pkg.sv
// Shared layout of the configuration word guarded by sr_write_guard.
// Assumes the field order below; neighbours decode the word by these positions.
package sr_guard_pkg;
    localparam int NLOCK    = 3;
    localparam int CFG_W    = 6;
    localparam int RSV_W    = 4;
    localparam int SRP_LSB  = 0;
    localparam int QE_POS   = SRP_LSB + 2;
    localparam int LOCK_LSB = QE_POS + 1;
    localparam int CFG_LSB  = LOCK_LSB + NLOCK;
    localparam int RSV_LSB  = CFG_LSB + CFG_W;
    localparam int WORD_W   = RSV_LSB + RSV_W;

    // Writable mask of the reserved slice: no position can be written.
    localparam logic [RSV_W-1:0] RSV_WRITABLE = '0;

    typedef struct packed {
        logic [RSV_W-1:0] rsv;
        logic [CFG_W-1:0] cfg;
        logic [NLOCK-1:0] lock;
        logic             qe;
        logic [1:0]       srp;
    } sr_t;

    typedef enum logic [1:0] {
        SRP_OPEN  = 2'b00,
        SRP_PIN   = 2'b01,
        SRP_POWER = 2'b10,
        SRP_OTP   = 2'b11
    } srp_e;
endpackage

// File: rtl/sr_guard_perm.sv
// Permission table for status writes.
// Decides from the protect field, quad-enable and the pin whether a status
// write may proceed. Assumes wp_n is already synchronised.
module sr_guard_perm (
    input  logic [1:0] srp,
    input  logic       qe,
    input  logic       wp_n,
    output logic       allow
);
    import sr_guard_pkg::*;

    logic pin_high;

    // Pin level as seen by the guard; a data lane never protects.
    always_comb pin_high = qe | wp_n;

    // Table lookup on the protect field.
    always_comb begin
        unique case (srp_e'(srp))
            SRP_OPEN:  allow = 1'b1;
            SRP_PIN:   allow = pin_high;
            SRP_POWER: allow = 1'b0;
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/sr_guard_merge.sv
// Builds the configuration word that an accepted status write leaves behind.
// Assumes the caller has already established that the write is permitted.
module sr_guard_merge (
    input  sr_guard_pkg::sr_t                    wr,
    input  logic [sr_guard_pkg::NLOCK-1:0]       cur_lock,
    input  logic                                 cur_qe,
    input  logic                                 qpi_mode,
    output sr_guard_pkg::sr_t                    nxt
);
    import sr_guard_pkg::*;

    // Field-wise merge: sticky locks, guarded quad-enable, masked reserved bits.
    always_comb begin
        nxt.srp  = wr.srp;
        nxt.cfg  = wr.cfg;
        nxt.lock = cur_lock | wr.lock;
        nxt.qe   = (qpi_mode && cur_qe) ? 1'b1 : wr.qe;
        nxt.rsv  = wr.rsv & RSV_WRITABLE;
    end
endmodule

// File: rtl/sr_guard_timer.sv
// Busy interval generator standing in for non-volatile write time.
// Assumes T_SR and T_ARRAY are at least 1 and that start comes only while idle.
module sr_guard_timer #(
    parameter int T_SR    = 6,
    parameter int T_ARRAY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic busy
);
    localparam int MAXT  = (T_SR > T_ARRAY) ? T_SR : T_ARRAY;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] LOAD_SR  = CNT_W'(T_SR - 1);
    localparam logic [CNT_W-1:0] LOAD_ARR = CNT_W'(T_ARRAY - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Load on start, count down to zero, then drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= long_sel ? LOAD_ARR : LOAD_SR;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/sr_write_guard.sv
// Status register write guard.
// Keeps the configuration word, the write-enable latch and the busy flag, and
// accepts status writes only as the protect field and pin allow.
// Assumes one command strobe per cycle and that rst_n marks a power cycle.
module sr_write_guard #(
    parameter int T_SR    = 6,
    parameter int T_ARRAY = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [sr_guard_pkg::WORD_W-1:0]   nv_word,
    input  logic                              cmd_wren,
    input  logic                              cmd_wrdi,
    input  logic                              cmd_wrsr,
    input  logic                              cmd_prog,
    input  logic                              cmd_erase,
    input  logic                              cmd_sec_prog,
    input  logic                              cmd_sec_erase,
    input  logic [sr_guard_pkg::WORD_W-1:0]   wr_data,
    input  logic                              wp_n,
    input  logic                              qpi_mode,
    output logic                              wr_accept,
    output logic                              wel,
    output logic                              busy,
    output logic [sr_guard_pkg::WORD_W-1:0]   sr_word
);
    import sr_guard_pkg::*;

    sr_t  cur_q, wr_s, nxt_s, img_s, pup_s;
    logic wel_q, acc_q, allow, busy_s;
    logic any_array, take_sr, take_arr;

    assign wr_s  = sr_t'(wr_data);
    assign img_s = sr_t'(nv_word);

    // Power-up image: a power-scoped lock returns to open, reserved bits drop.
    always_comb begin
        pup_s     = img_s;
        pup_s.srp = (srp_e'(img_s.srp) == SRP_POWER) ? SRP_OPEN : img_s.srp;
        pup_s.rsv = img_s.rsv & RSV_WRITABLE;
    end

    sr_guard_perm u_perm (
        .srp   (cur_q.srp),
        .qe    (cur_q.qe),
        .wp_n  (wp_n),
        .allow (allow)
    );

    sr_guard_merge u_merge (
        .wr       (wr_s),
        .cur_lock (cur_q.lock),
        .cur_qe   (cur_q.qe),
        .qpi_mode (qpi_mode),
        .nxt      (nxt_s)
    );

    // Command admission: idle, latch set, and for status writes, permitted.
    always_comb begin
        any_array = cmd_prog | cmd_erase | cmd_sec_prog | cmd_sec_erase;
        take_sr   = !busy_s && wel_q && cmd_wrsr && allow;
        take_arr  = !busy_s && wel_q && !cmd_wrsr && any_array;
    end

    sr_guard_timer #(
        .T_SR    (T_SR),
        .T_ARRAY (T_ARRAY)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take_sr | take_arr),
        .long_sel (take_arr),
        .busy     (busy_s)
    );

    // Configuration word and accept pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= pup_s;
            acc_q <= 1'b0;
        end else begin
            acc_q <= take_sr;
            if (take_sr) cur_q <= nxt_s;
        end
    end

    // Write-enable latch: cleared by accepted operations and write disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                       wel_q <= 1'b0;
        else if (take_sr || take_arr)     wel_q <= 1'b0;
        else if (!busy_s && cmd_wrdi)     wel_q <= 1'b0;
        else if (!busy_s && cmd_wren)     wel_q <= 1'b1;
    end

    assign wr_accept = acc_q;
    assign wel       = wel_q;
    assign busy      = busy_s;
    assign sr_word   = cur_q;
endmodule

// File: rtl/sr_write_guard_chk.sv
// Property checker for sr_write_guard, attached by bind below.
// Assumes the decoder raises at most one strobe per cycle.
module sr_write_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_prog,
    input logic       cmd_erase,
    input logic       cmd_sec_prog,
    input logic       cmd_sec_erase,
    input logic [1:0] wr_srp,
    input logic       wp_n,
    input logic       qpi_mode,
    input logic       wr_accept,
    input logic       wel,
    input logic       busy,
    input logic [1:0] sr_srp,
    input logic       sr_qe,
    input logic [2:0] sr_lock,
    input logic [3:0] sr_rsv
);
    logic armed;
    logic mod_cmd;

    // Marks cycles whose previous sample lies after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Any command that needs the latch.
    always_comb mod_cmd = cmd_wrsr | cmd_prog | cmd_erase | cmd_sec_prog | cmd_sec_erase;

    assert_one_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_erase, cmd_sec_prog, cmd_sec_erase}));

    assert_wren_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wren) |=> wel);

    assert_open_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wel && cmd_wrsr && sr_srp == 2'b00) |=> wr_accept);

    assert_pin_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wrsr && sr_srp == 2'b01 && !wp_n && !sr_qe) |=> !wr_accept);

    assert_power_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wrsr && sr_srp == 2'b10) |=> !wr_accept);

    assert_otp_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wrsr && sr_srp == 2'b11) |=> !wr_accept);

    assert_accept_cost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> (busy && !wel));

    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wel) && $stable(sr_srp) && $stable(sr_qe) && $stable(sr_lock)));

    assert_no_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wel && mod_cmd) |=> (!busy && !wel && !wr_accept));

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (($past(sr_lock) & ~sr_lock) == 3'b000));

    assert_qe_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wrsr && qpi_mode && sr_qe) |=> sr_qe);

    assert_rsv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sr_rsv == 4'b0000);

    assert_pulse_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !wr_accept);

    assert_srp_written_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wel && cmd_wrsr && sr_srp == 2'b00) |=> (sr_srp == $past(wr_srp)));
endmodule

bind sr_write_guard sr_write_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wren      (cmd_wren),
    .cmd_wrdi      (cmd_wrdi),
    .cmd_wrsr      (cmd_wrsr),
    .cmd_prog      (cmd_prog),
    .cmd_erase     (cmd_erase),
    .cmd_sec_prog  (cmd_sec_prog),
    .cmd_sec_erase (cmd_sec_erase),
    .wr_srp        (wr_data[1:0]),
    .wp_n          (wp_n),
    .qpi_mode      (qpi_mode),
    .wr_accept     (wr_accept),
    .wel           (wel),
    .busy          (busy),
    .sr_srp        (sr_word[1:0]),
    .sr_qe         (sr_word[2]),
    .sr_lock       (sr_word[5:3]),
    .sr_rsv        (sr_word[15:12])
);

// File: tb/sr_write_guard_test.sv
`timescale 1ns/1ps
// Self-checking bench for sr_write_guard: full sweep of the permission table
// followed by directed sequences for power cycles, busy, locks and reserved bits.
module sr_write_guard_test;
    localparam int T_SR    = 6;
    localparam int T_ARRAY = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] nv_word = '0;
    logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_prog = 0;
    logic        cmd_erase = 0, cmd_sec_prog = 0, cmd_sec_erase = 0;
    logic [15:0] wr_data = '0;
    logic        wp_n = 1'b1, qpi_mode = 1'b0;
    logic        wr_accept, wel, busy;
    logic [15:0] sr_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    sr_write_guard #(.T_SR(T_SR), .T_ARRAY(T_ARRAY)) uut (
        .clk(clk), .rst_n(rst_n), .nv_word(nv_word),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_sec_prog(cmd_sec_prog),
        .cmd_sec_erase(cmd_sec_erase), .wr_data(wr_data), .wp_n(wp_n),
        .qpi_mode(qpi_mode), .wr_accept(wr_accept), .wel(wel), .busy(busy),
        .sr_word(sr_word)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Word from fields: srp bits 1:0, qe bit 2, locks 5:3, cfg 11:6, reserved 15:12.
    function automatic logic [15:0] mk(input int cfg, input int lock, input int qe, input int srp);
        return 16'((cfg % 64) * 64 + (lock % 8) * 8 + (qe % 2) * 4 + (srp % 4));
    endfunction

    function automatic logic [15:0] after_pup(input logic [15:0] img);
        logic [1:0] s;
        s = (img[1:0] == 2'b10) ? 2'b00 : img[1:0];
        return {4'h0, img[11:2], s};
    endfunction

    function automatic logic [15:0] after_write(input logic [15:0] cur, input logic [15:0] d, input logic qpi);
        logic q;
        q = (qpi && cur[2]) ? 1'b1 : d[2];
        return {4'h0, d[11:6], cur[5:3] | d[5:3], q, d[1:0]};
    endfunction

    function automatic logic permitted(input logic [1:0] srp, input logic qe, input logic pin);
        case (srp)
            2'b00:   return 1'b1;
            2'b01:   return qe | pin;
            default: return 1'b0;
        endcase
    endfunction

    // Codes: 0 wren, 1 wrdi, 2 wrsr, 3 prog, 4 erase, 5 sec prog, 6 sec erase.
    task automatic issue(input int k, input logic [15:0] d);
        @(negedge clk);
        wr_data = d;
        cmd_wren = (k == 0); cmd_wrdi = (k == 1); cmd_wrsr = (k == 2);
        cmd_prog = (k == 3); cmd_erase = (k == 4); cmd_sec_prog = (k == 5);
        cmd_sec_erase = (k == 6);
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_prog = 0;
        cmd_erase = 0; cmd_sec_prog = 0; cmd_sec_erase = 0;
    endtask

    task automatic power(input logic [15:0] img);
        @(negedge clk);
        rst_n = 1'b0;
        nv_word = img;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic status_write(input logic [15:0] d);
        issue(0, '0);
        issue(2, d);
        wait_idle();
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp, d;
        int n;
        string tag;

        // Reset state (R5, R11).
        power(16'hF000);
        chk("R5 reset latch", wel, 0);
        chk("R5 reset busy", busy, 0);
        chk("R11 reset word", sr_word, 16'h0000);

        // Sweep of the permission table (R1..R4, R2 pin, R8 refused keeps latch).
        for (int s = 0; s < 4; s++) begin
            for (int q = 0; q < 2; q++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int m = 0; m < 2; m++) begin
                        case (s)
                            0: tag = "R1";
                            1: tag = "R2";
                            2: tag = "R3";
                            default: tag = "R4";
                        endcase
                        wp_n = 1'b1; qpi_mode = 1'b0;
                        power(mk(0, 0, q, 0));
                        exp = after_pup(mk(0, 0, q, 0));
                        d = 16'hF000 | mk(21, 0, q, s);
                        status_write(d);
                        exp = after_write(exp, d, 1'b0);
                        chk("R12 setup word", sr_word, exp);
                        wp_n = p[0]; qpi_mode = m[0];
                        issue(0, '0);
                        chk("R5 wren", wel, 1);
                        d = 16'hA000 | mk(s * 8 + q * 4 + p * 2 + m, 0, q, s);
                        issue(2, d);
                        n = int'(permitted(2'(s), q[0], p[0]));
                        chk({tag, " accept"}, wr_accept, n);
                        chk({tag, " R8 latch"}, wel, (n == 0));
                        chk({tag, " R6 busy"}, busy, n);
                        wait_idle();
                        if (n != 0) exp = after_write(exp, d, m[0]);
                        chk({tag, " word"}, sr_word, exp);
                    end
                end
            end
        end
        wp_n = 1'b1; qpi_mode = 1'b0;

        // R3: power cycle turns a stored 10 into 00.
        power(mk(7, 2, 0, 2));
        chk("R3 power clear", sr_word, mk(7, 2, 0, 0));

        // R4: 11 survives a power cycle and still refuses.
        power(16'h0000);
        status_write(mk(3, 0, 0, 3));
        d = sr_word;
        power(d);
        chk("R4 survives", sr_word, mk(3, 0, 0, 3));
        issue(0, '0);
        issue(2, mk(0, 0, 0, 0));
        chk("R4 refused", wr_accept, 0);
        chk("R4 word kept", sr_word, mk(3, 0, 0, 3));

        // R6: busy intervals for each operation class.
        power(16'h0000);
        issue(0, '0); issue(3, '0);
        chk("R6 prog latch", wel, 0);
        busy_len(n); chk("R6 prog length", n, T_ARRAY);
        issue(0, '0); issue(2, mk(1, 0, 0, 0));
        busy_len(n); chk("R6 status length", n, T_SR);
        issue(0, '0); issue(6, '0);
        busy_len(n); chk("R6 sec erase length", n, T_ARRAY);
        issue(0, '0); issue(5, '0);
        busy_len(n); chk("R6 sec prog length", n, T_ARRAY);

        // R7: commands during busy are ignored.
        issue(0, '0); issue(4, '0);
        exp = sr_word;
        issue(0, '0);
        chk("R7 busy still", busy, 1);
        chk("R7 wren ignored", wel, 0);
        issue(2, mk(9, 7, 1, 1));
        wait_idle();
        chk("R7 word kept", sr_word, exp);
        chk("R7 latch kept", wel, 0);

        // R8: commands without the latch.
        issue(3, '0);
        chk("R8 prog no busy", busy, 0);
        chk("R8 prog latch", wel, 0);
        issue(2, mk(5, 0, 0, 0));
        chk("R8 write refused", wr_accept, 0);
        chk("R8 word kept", sr_word, exp);
        issue(0, '0); issue(1, '0);
        chk("R5 wrdi clears", wel, 0);

        // R9: lock bits only accumulate.
        power(16'h0000);
        status_write(mk(0, 1, 0, 0));
        chk("R9 first lock", sr_word[5:3], 3'b001);
        status_write(mk(0, 2, 0, 0));
        chk("R9 or lock", sr_word[5:3], 3'b011);
        status_write(mk(0, 0, 0, 0));
        chk("R9 no clear", sr_word[5:3], 3'b011);

        // R10: quad-enable in and out of quad command mode.
        power(16'h0000);
        qpi_mode = 1'b1;
        status_write(mk(0, 0, 1, 0));
        chk("R10 set in quad mode", sr_word[2], 1);
        status_write(mk(0, 0, 0, 0));
        chk("R10 kept in quad mode", sr_word[2], 1);
        qpi_mode = 1'b0;
        status_write(mk(0, 0, 0, 0));
        chk("R10 cleared outside", sr_word[2], 0);

        // R11: reserved bits never stick.
        power(16'hF000 | mk(2, 0, 0, 0));
        chk("R11 power image", sr_word, mk(2, 0, 0, 0));
        issue(0, '0);
        issue(2, 16'hF000 | mk(4, 0, 0, 0));
        chk("R12 pulse", wr_accept, 1);
        @(negedge clk);
        chk("R12 pulse width", wr_accept, 0);
        wait_idle();
        chk("R11 write", sr_word, mk(4, 0, 0, 0));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule